// File: doc/BRIEF.md
# I2C Event and Error Flag Register

This block keeps the sticky event and error flags of an I2C/SMBus controller. The protocol engine sends it one-cycle event pulses, together with context levels that tell it whether the controller is master, whether clock stretching is off, whether a transfer or an address phase is running, and which reload, auto-end and byte-control settings are active. The block qualifies each pulse against that context and sets the matching flag. Each flag then holds until its own clear source arrives.

Software clears most flags by writing ones to a clear strobe. The reload-complete flag clears when a non-zero byte count is written. The transfer-complete flag clears when the start or stop control bit is written. Dropping the peripheral-enable level wipes every flag. The flags are packed into a 12-bit status word at fixed bit positions, and a registered interrupt request combines them with per-flag enables. A checksum mismatch also raises a one-cycle automatic-NACK request to the engine.

Top module: `i2c_evt_flags`

## Requirements
- R1: Status bit positions: 11 checksum error, 10 overrun/underrun, 9 arbitration lost, 8 bus error, 7 reload-complete, 6 transfer-complete, 5 stop seen, 4 NACK seen, 3 address match. Bits 2:0 always read 0, and all flags are 0 after reset. A flag becomes visible on the clock edge that samples its event.
- R2: While `periph_en` is 0, every flag is cleared at the next edge and no event can set one.
- R3: `ev_crc_bad` sets bit 11 and pulses `auto_nack` high for one cycle on the same edge. With `SMBUS_EN`=0, bit 11 and `auto_nack` stay 0.
- R4: `ev_ovr` sets bit 10 only when `is_master`=0 and `stretch_off`=1.
- R5: `ev_misplaced` sets bit 8 only when `in_transfer`=1 and the controller is not a slave in its address phase (`addr_phase`=1 with `is_master`=0).
- R6: `ev_cnt_done` sets bit 7 when `reload_on`=1 and either `is_master`=1 or `byte_ctrl`=1. Bit 7 clears only on `wr_cnt` with a non-zero `cnt_data`. A zero count write, or a clear-strobe bit 7, leaves it set.
- R7: `ev_cnt_done` sets bit 6 when `reload_on`=0, `autoend_on`=0 and `is_master`=1. Bit 6 clears only on `wr_ctl` with `ctl_start` or `ctl_stop` at 1.
- R8: `ev_stop` sets bit 5 as master only if `stop_by_me`=1, and as slave only if `addressed`=1.
- R9: When `wr_clr` is high, a 1 in `clr_data` at positions 11, 10, 9, 8, 5, 4 or 3 clears that flag. A 0 in `clr_data` changes nothing.
- R10: If a flag's set event and its clear request arrive on the same edge, the flag ends up set.
- R11: `irq` is registered. One cycle after any flag is 1 with its `irq_en` bit (same position) at 1, `irq` is 1; otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_en | input | 1 | Peripheral enable; 0 wipes all flags |
| ev_crc_bad | input | 1 | Received checksum mismatch pulse |
| ev_ovr | input | 1 | Overrun/underrun pulse |
| ev_arb_lost | input | 1 | Arbitration loss pulse |
| ev_misplaced | input | 1 | Misplaced start/stop pulse |
| ev_cnt_done | input | 1 | Programmed byte count reached pulse |
| ev_stop | input | 1 | Stop condition seen pulse |
| ev_nack | input | 1 | NACK received pulse |
| ev_addr_match | input | 1 | Own address matched pulse |
| is_master | input | 1 | Controller acts as master |
| stretch_off | input | 1 | Clock stretching disabled |
| in_transfer | input | 1 | Controller takes part in the current transfer |
| addr_phase | input | 1 | Address phase in progress |
| reload_on | input | 1 | Reload mode active |
| autoend_on | input | 1 | Automatic end mode active |
| byte_ctrl | input | 1 | Slave byte control enabled |
| stop_by_me | input | 1 | The stop was generated by this controller |
| addressed | input | 1 | Controller was addressed in this transfer |
| wr_clr | input | 1 | Clear strobe write |
| clr_data | input | 9 | Clear strobe data, bits 11:3 |
| wr_cnt | input | 1 | Byte-count write |
| cnt_data | input | CNT_W | Byte-count value written |
| wr_ctl | input | 1 | Control write |
| ctl_start | input | 1 | Start bit of control write |
| ctl_stop | input | 1 | Stop bit of control write |
| irq_en | input | 9 | Interrupt enables, bits 11:3 |
| status | output | 12 | Packed flag word |
| irq | output | 1 | Registered interrupt request |
| auto_nack | output | 1 | Automatic NACK request after checksum error |

## Verification
The hardest case to reach is an event pulse that lands on the same edge as the write that would clear its flag. Reaching it needs a flag that is already set and a pulse and a clear aligned to the same cycle. The stimulus therefore first sets the NACK flag. It then drives a NACK pulse together with a clear-strobe write of bit 4 in one cycle, and only afterwards issues a plain clear. The qualified flags are also driven in each wrong context (wrong role, stretching on, slave address phase, stop not owned, zero count write) before the right one, so that a missing qualifier shows up.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int ST_W  = 12;
  localparam int RSV   = 3;
  localparam int NFLAG = ST_W - RSV;

  // flag index k maps to status bit k + RSV
  localparam int F_ADDR = 0;
  localparam int F_NACK = 1;
  localparam int F_STOP = 2;
  localparam int F_TC   = 3;
  localparam int F_TCR  = 4;
  localparam int F_BERR = 5;
  localparam int F_ARB  = 6;
  localparam int F_OVR  = 7;
  localparam int F_CRC  = 8;

  // flags that a clear-strobe 1 removes
  localparam logic [NFLAG-1:0] W1C_MASK = 9'b1_1110_0111;

  typedef struct packed {
    logic is_master;
    logic stretch_off;
    logic in_transfer;
    logic addr_phase;
    logic reload_on;
    logic autoend_on;
    logic byte_ctrl;
    logic stop_by_me;
    logic addressed;
  } ctx_t;

  function automatic logic ovr_ok(input ctx_t c);
    return !c.is_master && c.stretch_off;
  endfunction

  function automatic logic berr_ok(input ctx_t c);
    return c.in_transfer && !(c.addr_phase && !c.is_master);
  endfunction

  function automatic logic tcr_ok(input ctx_t c);
    return c.reload_on && (c.is_master || c.byte_ctrl);
  endfunction

  function automatic logic tc_ok(input ctx_t c);
    return !c.reload_on && !c.autoend_on && c.is_master;
  endfunction

  function automatic logic stop_ok(input ctx_t c);
    return c.is_master ? c.stop_by_me : c.addressed;
  endfunction
endpackage

// File: rtl/i2c_evt_qualify.sv
module i2c_evt_qualify
  import i2c_flag_pkg::*;
#(
  parameter bit SMBUS_EN = 1'b1
) (
  input  ctx_t             ctx,
  input  logic             ev_crc_bad,
  input  logic             ev_ovr,
  input  logic             ev_arb_lost,
  input  logic             ev_misplaced,
  input  logic             ev_cnt_done,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             ev_addr_match,
  output logic [NFLAG-1:0] set_vec
);
  always_comb begin
    set_vec         = '0;
    set_vec[F_CRC]  = SMBUS_EN && ev_crc_bad;
    set_vec[F_OVR]  = ev_ovr && ovr_ok(ctx);
    set_vec[F_ARB]  = ev_arb_lost;
    set_vec[F_BERR] = ev_misplaced && berr_ok(ctx);
    set_vec[F_TCR]  = ev_cnt_done && tcr_ok(ctx);
    set_vec[F_TC]   = ev_cnt_done && tc_ok(ctx);
    set_vec[F_STOP] = ev_stop && stop_ok(ctx);
    set_vec[F_NACK] = ev_nack;
    set_vec[F_ADDR] = ev_addr_match;
  end
endmodule

// File: rtl/i2c_clr_decode.sv
module i2c_clr_decode
  import i2c_flag_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             wr_clr,
  input  logic [NFLAG-1:0] clr_data,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             wr_ctl,
  input  logic             ctl_start,
  input  logic             ctl_stop,
  output logic [NFLAG-1:0] clr_vec
);
  logic [NFLAG-1:0] w1c_hit;
  logic             tcr_clr;
  logic             tc_clr;

  assign w1c_hit = {NFLAG{wr_clr}} & clr_data & W1C_MASK;
  assign tcr_clr = wr_cnt && (cnt_data != '0);
  assign tc_clr  = wr_ctl && (ctl_start || ctl_stop);
  assign clr_vec = w1c_hit | (NFLAG'(tcr_clr) << F_TCR) | (NFLAG'(tc_clr) << F_TC);
endmodule

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (!en)   q <= 1'b0;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end
endmodule

// File: rtl/i2c_irq_reg.sv
module i2c_irq_reg
  import i2c_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  logic [NFLAG-1:0] irq_en,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(flags & irq_en);
  end
endmodule

// File: rtl/i2c_evt_flags.sv
module i2c_evt_flags
  import i2c_flag_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter bit SMBUS_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             periph_en,
  input  logic             ev_crc_bad,
  input  logic             ev_ovr,
  input  logic             ev_arb_lost,
  input  logic             ev_misplaced,
  input  logic             ev_cnt_done,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             ev_addr_match,
  input  logic             is_master,
  input  logic             stretch_off,
  input  logic             in_transfer,
  input  logic             addr_phase,
  input  logic             reload_on,
  input  logic             autoend_on,
  input  logic             byte_ctrl,
  input  logic             stop_by_me,
  input  logic             addressed,
  input  logic             wr_clr,
  input  logic [11:3]      clr_data,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] cnt_data,
  input  logic             wr_ctl,
  input  logic             ctl_start,
  input  logic             ctl_stop,
  input  logic [11:3]      irq_en,
  output logic [11:0]      status,
  output logic             irq,
  output logic             auto_nack
);
  ctx_t             ctx;
  logic [NFLAG-1:0] set_vec;   // qualified set requests
  logic [NFLAG-1:0] clr_vec;   // decoded clear requests
  logic [NFLAG-1:0] flag_q;

  assign ctx = '{is_master:   is_master,
                 stretch_off: stretch_off,
                 in_transfer: in_transfer,
                 addr_phase:  addr_phase,
                 reload_on:   reload_on,
                 autoend_on:  autoend_on,
                 byte_ctrl:   byte_ctrl,
                 stop_by_me:  stop_by_me,
                 addressed:   addressed};

  i2c_evt_qualify #(.SMBUS_EN(SMBUS_EN)) u_qual (
    .ctx           (ctx),
    .ev_crc_bad    (ev_crc_bad),
    .ev_ovr        (ev_ovr),
    .ev_arb_lost   (ev_arb_lost),
    .ev_misplaced  (ev_misplaced),
    .ev_cnt_done   (ev_cnt_done),
    .ev_stop       (ev_stop),
    .ev_nack       (ev_nack),
    .ev_addr_match (ev_addr_match),
    .set_vec       (set_vec)
  );

  i2c_clr_decode #(.CNT_W(CNT_W)) u_clr (
    .wr_clr    (wr_clr),
    .clr_data  (clr_data),
    .wr_cnt    (wr_cnt),
    .cnt_data  (cnt_data),
    .wr_ctl    (wr_ctl),
    .ctl_start (ctl_start),
    .ctl_stop  (ctl_stop),
    .clr_vec   (clr_vec)
  );

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    i2c_flag_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (periph_en),
      .set_i (set_vec[k]),
      .clr_i (clr_vec[k]),
      .q     (flag_q[k])
    );
  end

  assign status = {flag_q, {RSV{1'b0}}};

  i2c_irq_reg u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .flags  (flag_q),
    .irq_en (irq_en),
    .irq    (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) auto_nack <= 1'b0;
    else        auto_nack <= periph_en && set_vec[F_CRC];
  end
endmodule

// File: rtl/i2c_evt_flags_chk.sv
module i2c_evt_flags_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        periph_en,
  input logic        ev_ovr,
  input logic        ev_arb_lost,
  input logic        ev_cnt_done,
  input logic        ev_stop,
  input logic        is_master,
  input logic        stretch_off,
  input logic        reload_on,
  input logic        autoend_on,
  input logic        stop_by_me,
  input logic        addressed,
  input logic        wr_clr,
  input logic [11:3] clr_data,
  input logic [11:3] irq_en,
  input logic [11:0] status,
  input logic        irq,
  input logic        auto_nack
);
  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    status[2:0] == 3'b000);

  p_disable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !periph_en |=> status == 12'h000);

  p_nack_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    auto_nack |-> status[11]);

  p_ovr_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[10]) |-> $past(ev_ovr && !is_master && stretch_off));

  p_tc_master_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(ev_cnt_done && is_master && !reload_on && !autoend_on));

  p_stop_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[5]) |-> $past(ev_stop && (is_master ? stop_by_me : addressed)));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && clr_data[9] && !ev_arb_lost) |=> !status[9]);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_en && ev_arb_lost) |=> status[9]);

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(status[11:3] & irq_en)));
endmodule

bind i2c_evt_flags i2c_evt_flags_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .periph_en   (periph_en),
  .ev_ovr      (ev_ovr),
  .ev_arb_lost (ev_arb_lost),
  .ev_cnt_done (ev_cnt_done),
  .ev_stop     (ev_stop),
  .is_master   (is_master),
  .stretch_off (stretch_off),
  .reload_on   (reload_on),
  .autoend_on  (autoend_on),
  .stop_by_me  (stop_by_me),
  .addressed   (addressed),
  .wr_clr      (wr_clr),
  .clr_data    (clr_data),
  .irq_en      (irq_en),
  .status      (status),
  .irq         (irq),
  .auto_nack   (auto_nack)
);

// File: tb/i2c_evt_flags_bench.sv
`timescale 1ns/1ps
module i2c_evt_flags_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic periph_en, ev_crc_bad, ev_ovr, ev_arb_lost, ev_misplaced, ev_cnt_done;
  logic ev_stop, ev_nack, ev_addr_match;
  logic is_master, stretch_off, in_transfer, addr_phase, reload_on, autoend_on;
  logic byte_ctrl, stop_by_me, addressed;
  logic wr_clr, wr_cnt, wr_ctl, ctl_start, ctl_stop;
  logic [11:3] clr_data, irq_en;
  logic [7:0]  cnt_data;
  logic [11:0] status, status_n;
  logic irq, auto_nack, irq_n, auto_nack_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] m_st = '0;
  logic [11:0] q_st[$];
  logic        q_irq[$];
  logic        q_nk[$];
  string       q_rq[$];

  always #2.5 clk = ~clk;

  i2c_evt_flags u_i2c_evt_flags (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en),
    .ev_crc_bad(ev_crc_bad), .ev_ovr(ev_ovr), .ev_arb_lost(ev_arb_lost),
    .ev_misplaced(ev_misplaced), .ev_cnt_done(ev_cnt_done), .ev_stop(ev_stop),
    .ev_nack(ev_nack), .ev_addr_match(ev_addr_match),
    .is_master(is_master), .stretch_off(stretch_off), .in_transfer(in_transfer),
    .addr_phase(addr_phase), .reload_on(reload_on), .autoend_on(autoend_on),
    .byte_ctrl(byte_ctrl), .stop_by_me(stop_by_me), .addressed(addressed),
    .wr_clr(wr_clr), .clr_data(clr_data), .wr_cnt(wr_cnt), .cnt_data(cnt_data),
    .wr_ctl(wr_ctl), .ctl_start(ctl_start), .ctl_stop(ctl_stop), .irq_en(irq_en),
    .status(status), .irq(irq), .auto_nack(auto_nack));

  i2c_evt_flags #(.SMBUS_EN(1'b0)) u_nosmb (
    .clk(clk), .rst_n(rst_n), .periph_en(periph_en),
    .ev_crc_bad(ev_crc_bad), .ev_ovr(ev_ovr), .ev_arb_lost(ev_arb_lost),
    .ev_misplaced(ev_misplaced), .ev_cnt_done(ev_cnt_done), .ev_stop(ev_stop),
    .ev_nack(ev_nack), .ev_addr_match(ev_addr_match),
    .is_master(is_master), .stretch_off(stretch_off), .in_transfer(in_transfer),
    .addr_phase(addr_phase), .reload_on(reload_on), .autoend_on(autoend_on),
    .byte_ctrl(byte_ctrl), .stop_by_me(stop_by_me), .addressed(addressed),
    .wr_clr(wr_clr), .clr_data(clr_data), .wr_cnt(wr_cnt), .cnt_data(cnt_data),
    .wr_ctl(wr_ctl), .ctl_start(ctl_start), .ctl_stop(ctl_stop), .irq_en(irq_en),
    .status(status_n), .irq(irq_n), .auto_nack(auto_nack_n));

  // bench's own view of the flag rules, written from the requirements
  function automatic logic [11:0] model_next();
    logic [11:0] n;
    n = m_st;
    if (!periph_en) return 12'h000;
    if (wr_clr) begin
      if (clr_data[11]) n[11] = 1'b0;
      if (clr_data[10]) n[10] = 1'b0;
      if (clr_data[9])  n[9]  = 1'b0;
      if (clr_data[8])  n[8]  = 1'b0;
      if (clr_data[5])  n[5]  = 1'b0;
      if (clr_data[4])  n[4]  = 1'b0;
      if (clr_data[3])  n[3]  = 1'b0;
    end
    if (wr_cnt && cnt_data != 8'd0) n[7] = 1'b0;
    if (wr_ctl && (ctl_start || ctl_stop)) n[6] = 1'b0;
    if (ev_crc_bad) n[11] = 1'b1;
    if (ev_ovr && !is_master && stretch_off) n[10] = 1'b1;
    if (ev_arb_lost) n[9] = 1'b1;
    if (ev_misplaced && in_transfer && (is_master || !addr_phase)) n[8] = 1'b1;
    if (ev_cnt_done && reload_on && (is_master || byte_ctrl)) n[7] = 1'b1;
    if (ev_cnt_done && !reload_on && !autoend_on && is_master) n[6] = 1'b1;
    if (ev_stop && ((is_master && stop_by_me) || (!is_master && addressed))) n[5] = 1'b1;
    if (ev_nack) n[4] = 1'b1;
    if (ev_addr_match) n[3] = 1'b1;
    return n;
  endfunction

  task automatic drop_pulses();
    ev_crc_bad = 0; ev_ovr = 0; ev_arb_lost = 0; ev_misplaced = 0;
    ev_cnt_done = 0; ev_stop = 0; ev_nack = 0; ev_addr_match = 0;
    wr_clr = 0; clr_data = '0; wr_cnt = 0; cnt_data = '0;
    wr_ctl = 0; ctl_start = 0; ctl_stop = 0;
  endtask

  // driver: predict, let one edge pass, queue the prediction
  task automatic tick(input string rq);
    logic [11:0] nx;
    logic        iq;
    logic        nk;
    nx = model_next();
    iq = |(m_st[11:3] & irq_en);
    nk = periph_en && ev_crc_bad;
    @(posedge clk);
    q_st.push_back(nx);
    q_irq.push_back(iq);
    q_nk.push_back(nk);
    q_rq.push_back(rq);
    m_st = nx;
    @(negedge clk);
    drop_pulses();
  endtask

  // monitor: compare queued predictions away from the active edge
  always @(negedge clk) begin
    while (q_st.size() > 0) begin
      logic [11:0] es;
      logic        ei;
      logic        en;
      string       r;
      es = q_st.pop_front();
      ei = q_irq.pop_front();
      en = q_nk.pop_front();
      r  = q_rq.pop_front();
      checks++;
      if (status !== es || irq !== ei || auto_nack !== en) begin
        errors++;
        $display("FAIL %s: status=%h irq=%b nack=%b expected status=%h irq=%b nack=%b",
                 r, status, irq, auto_nack, es, ei, en);
      end
      checks++;
      if (status_n !== {1'b0, es[10:0]} || auto_nack_n !== 1'b0) begin
        errors++;
        $display("FAIL R3 (no SMBus, during %s): status=%h nack=%b expected status=%h nack=0",
                 r, status_n, auto_nack_n, {1'b0, es[10:0]});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drop_pulses();
    periph_en = 0; irq_en = '0;
    is_master = 0; stretch_off = 0; in_transfer = 0; addr_phase = 0;
    reload_on = 0; autoend_on = 0; byte_ctrl = 0; stop_by_me = 0; addressed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (status !== 12'h000 || irq !== 1'b0 || auto_nack !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: status=%h irq=%b expected status=000 irq=0", status, irq);
    end
    periph_en = 1;

    // R1 / R9: arbitration flag at bit 9, zero write ignored, one write clears
    ev_arb_lost = 1; tick("R1");
    wr_clr = 1; clr_data = '0; tick("R9");
    wr_clr = 1; clr_data[9] = 1; tick("R9");

    // R10: NACK set and clear on the same edge
    ev_nack = 1; tick("R1");
    ev_nack = 1; wr_clr = 1; clr_data[4] = 1; tick("R10");
    wr_clr = 1; clr_data[4] = 1; tick("R9");

    // R3: checksum error with automatic NACK request
    ev_crc_bad = 1; tick("R3");
    tick("R3");
    wr_clr = 1; clr_data[11] = 1; tick("R9");

    // R4: overrun qualification
    is_master = 1; stretch_off = 1; ev_ovr = 1; tick("R4");
    is_master = 0; stretch_off = 0; ev_ovr = 1; tick("R4");
    stretch_off = 1; ev_ovr = 1; tick("R4");
    wr_clr = 1; clr_data[10] = 1; tick("R9");

    // R5: bus error, not in slave address phase
    in_transfer = 1; addr_phase = 1; ev_misplaced = 1; tick("R5");
    addr_phase = 0; ev_misplaced = 1; tick("R5");
    wr_clr = 1; clr_data[8] = 1; tick("R9");
    in_transfer = 0; ev_misplaced = 1; tick("R5");

    // R6: reload-complete flag and its byte-count clear
    reload_on = 1; byte_ctrl = 0; ev_cnt_done = 1; tick("R6");
    byte_ctrl = 1; ev_cnt_done = 1; tick("R6");
    wr_cnt = 1; cnt_data = 8'd0; tick("R6");
    wr_clr = 1; clr_data[7] = 1; tick("R6");
    wr_cnt = 1; cnt_data = 8'd5; tick("R6");

    // R7: transfer-complete flag, master only, start/stop clear
    reload_on = 0; autoend_on = 0; ev_cnt_done = 1; tick("R7");
    is_master = 1; autoend_on = 1; ev_cnt_done = 1; tick("R7");
    autoend_on = 0; ev_cnt_done = 1; tick("R7");
    wr_ctl = 1; tick("R7");
    wr_clr = 1; clr_data[6] = 1; tick("R7");
    wr_ctl = 1; ctl_start = 1; tick("R7");
    ev_cnt_done = 1; tick("R7");
    wr_ctl = 1; ctl_stop = 1; tick("R7");

    // R8: stop flag qualification
    stop_by_me = 0; ev_stop = 1; tick("R8");
    stop_by_me = 1; ev_stop = 1; tick("R8");
    wr_clr = 1; clr_data[5] = 1; tick("R9");
    is_master = 0; addressed = 0; ev_stop = 1; tick("R8");
    addressed = 1; ev_stop = 1; tick("R8");

    // R11: interrupt follows enabled flags one cycle later
    irq_en = '0; irq_en[3] = 1; tick("R11");
    ev_addr_match = 1; tick("R11");
    tick("R11");
    irq_en = '0; irq_en[5] = 1; tick("R11");
    irq_en = '0; tick("R11");
    tick("R11");

    // R2: disable wipes flags and blocks events
    irq_en = '1;
    periph_en = 0; tick("R2");
    ev_addr_match = 1; ev_arb_lost = 1; tick("R2");
    periph_en = 1; tick("R2");
    tick("R2");

    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule